// File: doc/BRIEF.md
# Cascadable Nine-Tap FIR Filter

This block is a nine-tap FIR filter for sample streams at one sample per clock. A 12-bit two's complement sample is driven onto two data ports on the same clock. Each port feeds its own shift chain. The first port supplies three taps. The second port supplies the other six taps, which form one longer run. Each tap is multiplied by its own 10-bit fractional coefficient. The nine products are summed, and a 16-bit value from an upstream stage is added through a cascade input. The total is rounded at half an output LSB and leaves on a 16-bit cascade output on every clock.

Nine coefficient registers sit in three sets, and each set has one coefficient on each of the three coefficient ports. A 2-bit write code selects the set that loads on a clock edge. Several stages can be chained through the cascade ports with no loss of throughput, because the cascade path has a fixed latency of four clocks. A downstream user can round to a coarser LSB by driving a single 1 into the cascade input.

Top module: `fir9_cascade_filter`

## Requirements
- R1: A synchronous active-high reset clears the tap chains, pipeline registers and coefficient registers, so `cas_out` reads 0 on the edge after reset and stays 0 while the data inputs are 0.
- R2: The write code `wr_sel` updates one coefficient set on the clock edge where it is sampled. 0 holds all registers, 1 loads set 1, 2 loads set 2 and 3 loads set 3. Each load takes `ka_in`, `kb_in` and `kc_in` into that set's A, B and C coefficients. Under code 0 the coefficient ports have no effect on the output.
- R3: With the same sample S(e) on both data ports at edge e, the output after edge T is KA3·S(T-5) + KA2·S(T-6) + KA1·S(T-7) + KB3·S(T-8) + KB2·S(T-9) + KB1·S(T-10) + KC3·S(T-11) + KC2·S(T-12) + KC1·S(T-13) + cascade term. An impulse therefore gives nine outputs from edge e+5 to e+13, with its centre at e+9.
- R4: The A-coefficient taps (output delays 5 to 7) read only `a_in`. The B and C taps (delays 8 to 13) read only `b_in`.
- R5: A cascade input sampled at edge e is added to the output that appears after edge e+4.
- R6: Data inputs are integers. Coefficients have 9 fraction bits, with the MSB weighted -1. The cascade input and output carry 4 fraction bits, with the MSB weighted -2^11. A constant at weight 2^-5 is added before the bits below 2^-4 are dropped, so results with a fraction of exactly one half round up.
- R7: Driving a 1 into cascade input bit 3 (weight 2^-1) together with the built-in constant rounds the result to integer precision.
- R8: A new output is produced on every clock, with no enable, for any sequence of samples.
- R9: The arithmetic wraps modulo 2^16 at the output, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Sample for the A-coefficient taps (two's complement integer) |
| b_in | input | 12 | The same sample for the B- and C-coefficient taps |
| ka_in | input | 10 | A coefficient for the selected set |
| kb_in | input | 10 | B coefficient for the selected set |
| kc_in | input | 10 | C coefficient for the selected set |
| wr_sel | input | 2 | Coefficient write code: 0 hold, 1..3 load that set |
| cas_in | input | 16 | Cascade input, 12 integer and 4 fraction bits |
| cas_out | output | 16 | Rounded cascade output, 12 integer and 4 fraction bits |

## Verification
On every cycle, assertions check that reset clears the output and that code 0 leaves the coefficient sets untouched. They also check that a load code places the port values into the addressed set. Finally, they check that the first A tap and the first B tap hold the samples from exactly the expected number of clocks earlier. The bench scenarios are needed for the rest:
- the full placement of each coefficient against its delay;
- the four-clock cascade alignment;
- rounding at exactly half an LSB and rounding to integer precision through the cascade input;
- wrap-around on large sums.

A scoreboard reference checks these scenarios.

// File: rtl/fir9_pkg.sv
package fir9_pkg;

    // Port and arithmetic widths
    localparam int DATA_W    = 12;
    localparam int COEF_W    = 10;
    localparam int CAS_W     = 16;
    localparam int SEL_W     = 2;
    localparam int ROWS      = 3;                 // coefficient rows A, B, C
    localparam int SETS      = 3;                 // coefficient sets per row
    localparam int TAPS      = ROWS * SETS;
    localparam int COEF_FRAC = COEF_W - 1;        // 9 fraction bits
    localparam int CAS_FRAC  = 4;
    localparam int ALIGN     = COEF_FRAC - CAS_FRAC;
    localparam int PROD_W    = DATA_W + COEF_W;
    localparam int ACC_W     = PROD_W + $clog2(TAPS) + 1;

    // Tap placement relative to the input register
    localparam int A_FIRST   = 2;
    localparam int B_FIRST   = 5;
    localparam int A_DEPTH   = A_FIRST + SETS - 1;
    localparam int B_DEPTH   = B_FIRST + 2 * SETS - 1;
    localparam int CAS_DLY   = 3;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [CAS_W-1:0]  cas_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [SEL_W-1:0] {
        WR_HOLD = 2'd0,
        WR_SET1 = 2'd1,
        WR_SET2 = 2'd2,
        WR_SET3 = 2'd3
    } wr_sel_e;

    typedef struct packed {
        coef_t ka;
        coef_t kb;
        coef_t kc;
    } coef_set_t;

    // Delay (in stages past the input register) of the tap for row r, set j.
    // Higher-numbered sets sit nearer the head of each run.
    function automatic int tap_delay(input int r, input int j);
        if (r == 0)
            return A_FIRST + (SETS - 1 - j);
        return B_FIRST + (r - 1) * SETS + (SETS - 1 - j);
    endfunction

    function automatic acc_t round_const();
        return acc_t'(1) <<< (ALIGN - 1);
    endfunction

endpackage

// File: rtl/fir9_tap_line.sv
module fir9_tap_line #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] taps [DEPTH+1]
);

    assign taps[0] = din;

    generate
        for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
            logic [W-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= taps[g-1];
            end
            assign taps[g] = stage_q;
        end
    endgenerate

endmodule

// File: rtl/fir9_coef_bank.sv
module fir9_coef_bank
    import fir9_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wr_sel_e   sel,
    input  coef_set_t wr_data,
    output coef_set_t bank [SETS]
);

    generate
        for (genvar j = 0; j < SETS; j++) begin : g_set
            always_ff @(posedge clk) begin
                if (rst)
                    bank[j] <= '0;
                else if (sel == wr_sel_e'(SEL_W'(j + 1)))
                    bank[j] <= wr_data;
            end
        end
    endgenerate

    // R2
    coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == WR_HOLD) |=> ($stable(bank[0]) && $stable(bank[1]) && $stable(bank[2])));

    // R2
    coef_load_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == WR_SET2) |=> (bank[1] == $past(wr_data)));

endmodule

// File: rtl/fir9_mac.sv
module fir9_mac
    import fir9_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sample_t smp [TAPS],
    input  coef_t   cf  [TAPS],
    input  cas_t    cas_in,
    output cas_t    y
);

    prod_t prod_q [TAPS];
    acc_t  sum_c;
    acc_t  sum_q;
    acc_t  total_c;
    cas_t  y_q;

    // Stage 1: one registered product per tap
    generate
        for (genvar i = 0; i < TAPS; i++) begin : g_mul
            always_ff @(posedge clk) begin
                if (rst) prod_q[i] <= '0;
                else     prod_q[i] <= prod_t'(smp[i]) * prod_t'(cf[i]);
            end
        end
    endgenerate

    // Stage 2: sum of products
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < TAPS; i++)
            sum_c = sum_c + acc_t'(prod_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= sum_c;
    end

    // Stage 3: cascade add with half-LSB constant, then drop low bits
    always_comb
        total_c = sum_q + (acc_t'(cas_in) <<< ALIGN) + round_const();

    always_ff @(posedge clk) begin
        if (rst) y_q <= '0;
        else     y_q <= total_c[ALIGN +: CAS_W];
    end

    assign y = y_q;

endmodule

// File: rtl/fir9_cascade_filter.sv
module fir9_cascade_filter
    import fir9_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [COEF_W-1:0] ka_in,
    input  logic [COEF_W-1:0] kb_in,
    input  logic [COEF_W-1:0] kc_in,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CAS_W-1:0]  cas_in,
    output logic [CAS_W-1:0]  cas_out
);

    // Input registers
    logic [DATA_W-1:0] a_q, b_q;
    logic [CAS_W-1:0]  cas_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            cas_q <= '0;
        end else begin
            a_q   <= a_in;
            b_q   <= b_in;
            cas_q <= cas_in;
        end
    end

    // Tap chains: a short one for the A row and a long one shared by B and C
    logic [DATA_W-1:0] a_taps   [A_DEPTH+1];
    logic [DATA_W-1:0] b_taps   [B_DEPTH+1];
    logic [CAS_W-1:0]  cas_taps [CAS_DLY+1];

    fir9_tap_line #(.W(DATA_W), .DEPTH(A_DEPTH)) a_line_i (
        .clk (clk), .rst (rst), .din (a_q), .taps (a_taps)
    );

    fir9_tap_line #(.W(DATA_W), .DEPTH(B_DEPTH)) b_line_i (
        .clk (clk), .rst (rst), .din (b_q), .taps (b_taps)
    );

    fir9_tap_line #(.W(CAS_W), .DEPTH(CAS_DLY)) cas_line_i (
        .clk (clk), .rst (rst), .din (cas_q), .taps (cas_taps)
    );

    // Coefficient sets
    coef_set_t wr_data;
    coef_set_t bank [SETS];

    assign wr_data = '{ka: coef_t'(ka_in), kb: coef_t'(kb_in), kc: coef_t'(kc_in)};

    fir9_coef_bank coef_i (
        .clk     (clk),
        .rst     (rst),
        .sel     (wr_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .bank    (bank)
    );

    // Tap-to-coefficient routing
    sample_t tap_smp  [TAPS];
    coef_t   tap_coef [TAPS];

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            for (genvar j = 0; j < SETS; j++) begin : g_set
                localparam int IDX = r * SETS + j;
                localparam int DLY = tap_delay(r, j);
                if (r == 0) begin : g_a
                    assign tap_smp[IDX]  = sample_t'(a_taps[DLY]);
                    assign tap_coef[IDX] = bank[j].ka;
                end else if (r == 1) begin : g_b
                    assign tap_smp[IDX]  = sample_t'(b_taps[DLY]);
                    assign tap_coef[IDX] = bank[j].kb;
                end else begin : g_c
                    assign tap_smp[IDX]  = sample_t'(b_taps[DLY]);
                    assign tap_coef[IDX] = bank[j].kc;
                end
            end
        end
    endgenerate

    cas_t y;

    fir9_mac mac_i (
        .clk    (clk),
        .rst    (rst),
        .smp    (tap_smp),
        .cf     (tap_coef),
        .cas_in (cas_t'(cas_taps[CAS_DLY])),
        .y      (y)
    );

    assign cas_out = y;

    // Cycles since reset, saturating, for the history-based checks
    logic [3:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != '1) since_rst <= since_rst + 4'd1;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (cas_out == '0));

    // R4
    a_tap_align_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst > 4'd12) |-> (a_taps[A_FIRST] == $past(a_in, 3)));

    // R3
    b_tap_align_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst > 4'd12) |-> (b_taps[B_FIRST] == $past(b_in, 6)));

endmodule

// File: tb/fir9_cascade_filter_tb_top.sv
module fir9_cascade_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HMASK      = 4095;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] a_in = '0, b_in = '0;
    logic [9:0]  ka_in = '0, kb_in = '0, kc_in = '0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] cas_in = '0;
    logic [15:0] cas_out;

    fir9_cascade_filter dut_i (
        .clk (clk), .rst (rst), .a_in (a_in), .b_in (b_in),
        .ka_in (ka_in), .kb_in (kb_in), .kc_in (kc_in),
        .wr_sel (wr_sel), .cas_in (cas_in), .cas_out (cas_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Stimulus history and reference coefficients (index 0..2 = set 1..3)
    int ha [HMASK+1];
    int hb [HMASK+1];
    int hc [HMASK+1];
    int ka [3];
    int kb [3];
    int kc [3];

    typedef struct {
        int    t;
        int    val;
        string tag;
    } exp_t;
    exp_t sbq [$];

    function automatic int get(ref int h [HMASK+1], input int i);
        if (i < 0) return 0;
        return h[i & HMASK];
    endfunction

    // Reference from R3, R5, R6, R9
    function automatic int expect_at(int t);
        longint acc = 16;
        for (int j = 0; j < 3; j++) begin
            acc += longint'(ka[j]) * get(ha, t - 7 + j);
            acc += longint'(kb[j]) * get(hb, t - 10 + j);
            acc += longint'(kc[j]) * get(hb, t - 13 + j);
        end
        acc += 32 * longint'(get(hc, t - 4));
        return int'((acc >>> 5) & 64'hFFFF);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Driver: one sample per clock; optionally queues the result it completes
    task automatic step(int a, int b, int c, bit push, string tag);
        int e;
        @(negedge clk);
        a_in   = 12'(a);
        b_in   = 12'(b);
        cas_in = 16'(c);
        e = cyc + 1;
        ha[e & HMASK] = a;
        hb[e & HMASK] = b;
        hc[e & HMASK] = c;
        if (push) begin
            exp_t it;
            it.t   = e + 4;
            it.val = expect_at(e + 4);
            it.tag = tag;
            sbq.push_back(it);
        end
    endtask

    task automatic idle(int n, bit push, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, push, tag);
    endtask

    task automatic load(int set, int a, int b, int c);
        @(negedge clk);
        ka_in  = 10'(a);
        kb_in  = 10'(b);
        kc_in  = 10'(c);
        wr_sel = 2'(set);
        step(0, 0, 0, 0, "");
        wr_sel = 2'd0;
        ka[set-1] = a;
        kb[set-1] = b;
        kc[set-1] = c;
    endtask

    task automatic load_all(int a1, int a2, int a3, int b1, int b2, int b3,
                            int c1, int c2, int c3);
        load(1, a1, b1, c1);
        load(2, a2, b2, c2);
        load(3, a3, b3, c3);
    endtask

    // Monitor: compare each queued result in its cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].t <= cyc) begin
            exp_t it;
            it = sbq.pop_front();
            if (it.t < cyc) check({it.tag, " missed"}, -1, it.val);
            else            check(it.tag, int'(cas_out), it.val);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 output cleared by reset", int'(cas_out), 0);
        idle(4, 1, "R1 idle stays zero");
        idle(14, 0, "");

        // R3: impulse of 32 (1.0 at the output LSB scale) on both ports
        load_all(3, 5, 7, -2, 11, 13, 17, -19, 23);
        step(32, 32, 0, 1, "R3 impulse");
        idle(16, 1, "R3 impulse response");

        // R2: coefficient ports move under hold code, then only set 2 reloads
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ka_in = 10'(100 + i); kb_in = 10'(-50 - i); kc_in = 10'(77);
            step(0, 0, 0, 0, "");
        end
        step(32, 32, 0, 1, "R2 hold code keeps coefficients");
        idle(16, 1, "R2 hold response");
        load(2, -40, 60, -80);
        step(32, 32, 0, 1, "R2 set 2 reload");
        idle(16, 1, "R2 reload response");

        // R4: ports feed separate taps
        step(32, 0, 0, 1, "R4 A-only impulse");
        idle(16, 1, "R4 A-only response");
        step(0, 32, 0, 1, "R4 B-only impulse");
        idle(16, 1, "R4 B-only response");

        // R5: cascade pass-through with data at zero
        for (int i = 0; i < 8; i++) step(0, 0, (i * 4099) - 12000, 1, "R5 cascade latency");
        idle(8, 1, "R5 cascade tail");

        // R6: half-LSB rounding with a single A tap
        load_all(0, 0, 16, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 1, "R6 exact half rounds up");
        step(-1, -1, 0, 1, "R6 negative half");
        step(3, 3, 0, 1, "R6 one and a half");
        idle(12, 1, "R6 tail");
        load(3, 15, 0, 0);
        step(1, 1, 0, 1, "R6 below half");
        idle(12, 1, "R6 tail");

        // R7: integer rounding through cascade bit 3
        load(3, 1, 0, 0);
        step(256, 256, 0, 1, "R7 half without cascade bit");
        step(0, 0, 0, 1, "R7");
        step(256, 256, 0, 1, "R7");
        step(0, 0, 8, 1, "R7 cascade bit 3 rounds to integer");
        idle(12, 1, "R7 tail");

        // R8: full-rate stream with cascade input
        load_all(-37, 91, 12, 55, -120, 200, 8, -66, 140);
        lfsr = 16'hACE1;
        for (int i = 0; i < 48; i++) begin
            int s;
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
            s = (lfsr % 601) - 300;
            step(s, s, (lfsr & 16'h0FFF) - 2048, 1, "R8 stream");
        end
        idle(16, 1, "R8 tail");

        // R9: wrap-around at large magnitude
        load_all(511, 511, 511, 511, 511, 511, 511, 511, 511);
        for (int i = 0; i < 12; i++) step(2047, 2047, 32767, 1, "R9 wrap");
        for (int i = 0; i < 6; i++) step(-2048, -2048, -32768, 1, "R9 wrap negative");
        idle(16, 1, "R9 tail");

        // R1: reset mid-stream clears the output
        for (int i = 0; i < 6; i++) step(500, 500, 1000, 0, "");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset during activity", int'(cas_out), 0);
        rst = 1'b0;
        finish_run();
    end

endmodule